// File: doc/BRIEF.md
# Selectable-Rate Audio Deemphasis Filter

This block applies the standard analog deemphasis response to a two-channel audio stream running at four times the source sampling rate. It sits between the second and third interpolation stages of an oversampling chain. A first-order recursive filter with one pole and one zero matches both the gain and the phase of the analog network. The coefficients come from one of three constant sets, one for each source rate of 32, 44.1 and 48 kHz. A two-bit rate code picks the set.

Each channel has its own enable. With the enable low, samples pass through unchanged. With it high, the channel filters with its own history registers. Those registers are cleared whenever the enable toggles, so a channel always restarts from rest. Left and right samples arrive together under one valid strobe. The results leave one cycle later under their own strobe.

Top module: `deemph_filter`

## Requirements
- R1: After reset, `out_valid`, `out_left`, `out_right` and `rate_err` are 0, both channels' history is zero, and the remembered coefficient set is the 44.1 kHz one (code 00).
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, on the following clock edge. No other cycle raises `out_valid`.
- R3: A channel whose enable is low outputs its input sample unchanged, one cycle later.
- R4: An enabled channel keeps a scaled state `s` (SAMPLE_W+GUARD_F bits, value y·2^GUARD_F) and the previous input `xp`. For each sample `x` it computes `acc = (b0·x + b1·xp)·2^GUARD_F + a1·s`. The new state is `s' = floor(acc / 2^15)`, clamped to the signed SAMPLE_W+GUARD_F range. The output is `floor(s' / 2^GUARD_F)`. After the sample, `xp = x` and `s = s'`.
- R5: Coefficients are Q1.15 values selected by `rate_sel` = {first select bit, second select bit}:
  - 00 (44.1 kHz): b0=11061, b1=-7545, a1=29252
  - 01 (48 kHz): b0=10966, b1=-7722, a1=29524
  - 11 (32 kHz): b0=11492, b1=-6744, a1=28020

  A valid code takes effect for a sample presented in the same cycle.
- R6: Code 10 is invalid. While it is applied, the filter keeps using the last valid coefficient set, and `rate_err` is high on the cycle after each cycle the code is present. It drops one cycle after a valid code returns.
- R7: The left and right enables act independently. The setting of one channel never changes the other channel's output.
- R8: A channel's history (`s` and `xp`) is zero while its enable is low. It is also cleared in any cycle in which its enable differs from its value in the previous cycle. A re-enabled channel therefore filters from rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample pair present |
| in_left | input | SAMPLE_W | Left input sample, signed |
| in_right | input | SAMPLE_W | Right input sample, signed |
| rate_sel | input | 2 | Source-rate code (see R5, R6) |
| en_left | input | 1 | Left deemphasis enable, high = filter |
| en_right | input | 1 | Right deemphasis enable, high = filter |
| out_valid | output | 1 | Output pair present |
| out_left | output | SAMPLE_W | Left output sample, signed |
| out_right | output | SAMPLE_W | Right output sample, signed |
| rate_err | output | 1 | Invalid rate code seen on previous cycle |

## Verification
The bench applies the invalid rate code right after reset and again mid-stream. A design that reset to the wrong set, or that loaded garbage coefficients on code 10, would produce filtered values that disagree with the 44.1 kHz or last-valid recurrence. The bench toggles one channel's enable off and back on between samples and follows with an impulse. A design that failed to clear the history would leak the earlier decaying tail into that response. Full-scale alternating inputs exercise the widest products, which exposes a narrow accumulator or a logical rather than arithmetic shift. Mixed enables expose cross-channel coupling.

// File: rtl/deemph_pkg.sv
// Shared types and the constant coefficient tables for the deemphasis filter.
// Assumes Q1.15 coefficients, computed by bilinear transform at 4x the
// source rate, scaled so each set has exactly unity gain at DC.
package deemph_pkg;

    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 15;

    typedef logic [1:0] rate_code_t;

    localparam rate_code_t RATE_44K1 = 2'b00;
    localparam rate_code_t RATE_48K  = 2'b01;
    localparam rate_code_t RATE_BAD  = 2'b10;
    localparam rate_code_t RATE_32K  = 2'b11;

    typedef struct packed {
        logic signed [COEF_W-1:0] b0;
        logic signed [COEF_W-1:0] b1;
        logic signed [COEF_W-1:0] a1;
    } coef_t;

    // Map a valid rate code to its coefficient set (invalid falls to 44.1).
    function automatic coef_t coef_for(input rate_code_t code);
        coef_t c;
        case (code)
            RATE_48K: begin
                c.b0 = 16'sd10966;
                c.b1 = -16'sd7722;
                c.a1 = 16'sd29524;
            end
            RATE_32K: begin
                c.b0 = 16'sd11492;
                c.b1 = -16'sd6744;
                c.a1 = 16'sd28020;
            end
            default: begin
                c.b0 = 16'sd11061;
                c.b1 = -16'sd7545;
                c.a1 = 16'sd29252;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/deemph_rate_sel.sv
// Rate-code decoder: passes a valid code straight through to the coefficient
// table and remembers it; on the invalid code it reuses the remembered code
// and raises an error flag for one cycle per invalid cycle.
// Assumes rate_i is synchronous to clk.
module deemph_rate_sel
    import deemph_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rate_code_t rate_i,
    output coef_t      coef_o,
    output logic       err_o
);

    rate_code_t held_q;
    rate_code_t active;

    // Choose the live code, or fall back to the last valid one.
    always_comb begin
        active = (rate_i == RATE_BAD) ? held_q : rate_i;
    end

    // Remember the code in force and flag invalid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= RATE_44K1;
            err_o  <= 1'b0;
        end else begin
            held_q <= active;
            err_o  <= (rate_i == RATE_BAD);
        end
    end

    assign coef_o = coef_for(active);

    // R6: an invalid code must not disturb the remembered set
    a_r6_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == RATE_BAD) |=> $stable(held_q));

endmodule

// File: rtl/deemph_chan.sv
// One channel of the first-order deemphasis IIR.
// y-state is kept with GUARD_F extra fractional bits and saturated.
// History clears while disabled and on any enable toggle.
// Output is registered; bypass passes the input through unchanged.
// Assumes coef_i is stable in the cycle valid_i is high.
module deemph_chan
    import deemph_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int GUARD_F  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic                       valid_i,
    input  logic signed [SAMPLE_W-1:0] x_i,
    input  coef_t                      coef_i,
    output logic signed [SAMPLE_W-1:0] y_o
);

    localparam int SW    = SAMPLE_W + GUARD_F;
    localparam int ACC_W = COEF_W + SW + 2;
    localparam logic signed [ACC_W-1:0] SMAX = {{(ACC_W-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SMIN = {{(ACC_W-SW+1){1'b1}}, {(SW-1){1'b0}}};

    logic                       en_q;
    logic signed [SAMPLE_W-1:0] xp_q;
    logic signed [SW-1:0]       s_q;

    logic                       en_chg;
    logic signed [ACC_W-1:0]    xe, xpe, se, b0e, b1e, a1e;
    logic signed [ACC_W-1:0]    acc, shifted;
    logic signed [SW-1:0]       s_new;
    logic signed [SW-1:0]       y_wide;

    // Form the recurrence from history (zeroed when enable just toggled).
    always_comb begin
        en_chg  = (en_i != en_q);
        xe      = ACC_W'(x_i);
        xpe     = en_chg ? '0 : ACC_W'(xp_q);
        se      = en_chg ? '0 : ACC_W'(s_q);
        b0e     = ACC_W'(coef_i.b0);
        b1e     = ACC_W'(coef_i.b1);
        a1e     = ACC_W'(coef_i.a1);
        acc     = ((b0e * xe + b1e * xpe) <<< GUARD_F) + a1e * se;
        shifted = acc >>> COEF_FRAC;
        if (shifted > SMAX) begin
            s_new = SMAX[SW-1:0];
        end else if (shifted < SMIN) begin
            s_new = SMIN[SW-1:0];
        end else begin
            s_new = shifted[SW-1:0];
        end
        y_wide  = s_new >>> GUARD_F;
    end

    // Track the enable and update or clear the filter history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            xp_q <= '0;
            s_q  <= '0;
        end else begin
            en_q <= en_i;
            if (en_i && valid_i) begin
                xp_q <= x_i;
                s_q  <= s_new;
            end else if (!en_i || en_chg) begin
                xp_q <= '0;
                s_q  <= '0;
            end
        end
    end

    // Register the filtered or bypassed sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o <= '0;
        end else if (valid_i) begin
            y_o <= en_i ? y_wide[SAMPLE_W-1:0] : x_i;
        end
    end

    // R3: bypass reproduces the input exactly
    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !en_i) |=> (y_o == $past(x_i)));

    // R8: an enable toggle without a sample leaves empty history
    a_r8_clear_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_i != en_q) && !valid_i) |=> (s_q == '0 && xp_q == '0));

    // R8: a disabled channel holds no history
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (s_q == '0 && xp_q == '0));

endmodule

// File: rtl/deemph_filter.sv
// Two-channel selectable-rate deemphasis filter, top level.
// One rate decoder feeds both channels. Each channel has its own enable.
// The output strobe follows the input strobe by one cycle.
// Assumes left and right samples arrive together under in_valid.
module deemph_filter
    import deemph_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int GUARD_F  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic [1:0]                 rate_sel,
    input  logic                       en_left,
    input  logic                       en_right,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic                       rate_err
);

    localparam int NCH = 2;

    coef_t                      coef;
    logic signed [SAMPLE_W-1:0] x_arr [NCH];
    logic signed [SAMPLE_W-1:0] y_arr [NCH];
    logic                       en_arr [NCH];

    assign x_arr[0]  = in_left;
    assign x_arr[1]  = in_right;
    assign en_arr[0] = en_left;
    assign en_arr[1] = en_right;
    assign out_left  = y_arr[0];
    assign out_right = y_arr[1];

    deemph_rate_sel u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate_i (rate_sel),
        .coef_o (coef),
        .err_o  (rate_err)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        deemph_chan #(
            .SAMPLE_W (SAMPLE_W),
            .GUARD_F  (GUARD_F)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_arr[g]),
            .valid_i (in_valid),
            .x_i     (x_arr[g]),
            .coef_i  (coef),
            .y_o     (y_arr[g])
        );
    end

    // Delay the sample strobe to line up with the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // R2: every input sample yields an output one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no output without an input
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6: invalid code raises the flag next cycle
    a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b10) |=> rate_err);

endmodule

// File: tb/tb_deemph_filter.sv
module tb_deemph_filter;

    localparam int W  = 16;
    localparam int GF = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_left = '0;
    logic signed [W-1:0] in_right = '0;
    logic [1:0]          rate_sel = 2'b00;
    logic                en_left = 1'b0;
    logic                en_right = 1'b0;
    logic                out_valid;
    logic signed [W-1:0] out_left;
    logic signed [W-1:0] out_right;
    logic                rate_err;

    deemph_filter #(.SAMPLE_W(W), .GUARD_F(GF)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .rate_sel(rate_sel),
        .en_left(en_left), .en_right(en_right), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .rate_err(rate_err)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        int    l;
        int    r;
        int    at;
        string tag;
    } exp_t;
    exp_t q[$];

    // reference model state per channel
    longint m_s[2];
    longint m_xp[2];
    bit     m_en[2];
    int     m_code = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic void coefs(input int code, output longint b0, output longint b1, output longint a1);
        case (code)
            1:       begin b0 = 10966; b1 = -7722; a1 = 29524; end
            3:       begin b0 = 11492; b1 = -6744; a1 = 28020; end
            default: begin b0 = 11061; b1 = -7545; a1 = 29252; end
        endcase
    endfunction

    function automatic int model(input int ch, input int x);
        longint b0, b1, a1, acc, sn;
        if (!m_en[ch]) return x;
        coefs(m_code, b0, b1, a1);
        acc = (b0 * x + b1 * m_xp[ch]) * (64'sd1 <<< GF) + a1 * m_s[ch];
        sn = acc >>> 15;
        if (sn > 524287) sn = 524287;
        if (sn < -524288) sn = -524288;
        m_xp[ch] = x;
        m_s[ch] = sn;
        return int'(sn >>> GF);
    endfunction

    // driver: present one sample pair, push expected results
    task automatic send(input int l, input int r, input string tag);
        exp_t e;
        @(negedge clk);
        if (rate_sel != 2'b10) m_code = int'(rate_sel);
        e.l = model(0, l);
        e.r = model(1, r);
        e.at = cyc + 1;
        e.tag = tag;
        q.push_back(e);
        in_left = W'(l);
        in_right = W'(r);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_en(input bit l, input bit r);
        @(negedge clk);
        en_left = l;
        en_right = r;
        if (l != m_en[0] || !l) begin m_s[0] = 0; m_xp[0] = 0; end
        if (r != m_en[1] || !r) begin m_s[1] = 0; m_xp[1] = 0; end
        m_en[0] = l;
        m_en[1] = r;
        @(negedge clk);
    endtask

    task automatic set_rate(input logic [1:0] c);
        @(negedge clk);
        rate_sel = c;
        @(negedge clk);
    endtask

    // monitor: compare each produced pair against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.at, {e.tag, " R2 latency"}, cyc, e.at);
                    check(int'(out_left) == e.l, {e.tag, " left"}, out_left, e.l);
                    check(int'(out_right) == e.r, {e.tag, " right"}, out_right, e.r);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin m_s[c] = 0; m_xp[c] = 0; m_en[c] = 0; end
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(out_left == 0 && out_right == 0, "R1 outputs", out_left, 0);
        check(rate_err == 1'b0, "R1 rate_err", rate_err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rate_sel = 2'b10;
        @(negedge clk);
        #1;
        check(rate_err == 1'b1, "R6 flag after invalid", rate_err, 1);

        // R3: bypass on both channels
        send(12345, -32768, "R3 bypass a");
        send(32767, -1, "R3 bypass b");

        // R1/R6: enabled with invalid code uses reset-default 44.1 set
        set_en(1, 1);
        send(10000, -10000, "R1 default set");
        for (int i = 0; i < 6; i++) send(10000, -10000, "R4 step 44.1");
        set_rate(2'b00);
        check(rate_err == 1'b0, "R6 flag clears", rate_err, 0);
        for (int i = 0; i < 8; i++) begin
            int v = ((i * 7919 + 311) % 65536) - 32768;
            send(v, -v - 1, "R4 mixed pattern");
        end
        for (int i = 0; i < 6; i++) send((i % 2) ? 32767 : -32768, (i % 2) ? -32768 : 32767, "R4 full-scale alternate");

        // R5: other rate sets, switched mid-stream
        set_rate(2'b01);
        for (int i = 0; i < 5; i++) send(20000 - i * 3000, 5000, "R5 48k set");
        set_rate(2'b11);
        for (int i = 0; i < 5; i++) send(-15000, 7000 * i, "R5 32k set");

        // R6: invalid code mid-stream keeps the 32k set
        set_rate(2'b10);
        check(rate_err == 1'b1, "R6 flag mid-stream", rate_err, 1);
        for (int i = 0; i < 4; i++) send(9000, -9000, "R6 held set");
        set_rate(2'b01);
        check(rate_err == 1'b0, "R6 flag drop", rate_err, 0);

        // R7: left filtered, right bypassed, and the reverse
        set_en(1, 0);
        for (int i = 0; i < 4; i++) send(8000, 8000, "R7 left only");
        set_en(0, 1);
        for (int i = 0; i < 4; i++) send(-8000, -8000, "R7 right only");

        // R8: toggle right off/on quickly, then impulse from rest
        set_en(1, 1);
        for (int i = 0; i < 4; i++) send(30000, 30000, "R8 charge");
        @(negedge clk);
        en_right = 1'b0;
        @(negedge clk);
        en_right = 1'b1;
        m_s[1] = 0; m_xp[1] = 0;
        @(negedge clk);
        send(16384, 16384, "R8 impulse after toggle");
        for (int i = 0; i < 4; i++) send(0, 0, "R8 impulse tail");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2 all outputs seen", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule